// File: doc/BRIEF.md
# Moving Box Video Overlay Stage

This is a streaming pixel stage meant to be chained with copies of itself. Each pixel is three 8-bit luma and chroma components. The stage picks a background for every pixel. It can forward the upstream pixel, generate a horizontal or vertical ramp, or fill with black. It then paints one foreground layer on top. The layer is either a solid square box that travels and bounces around the frame, or a pair of one-pixel cross-hair lines. When two stages run in series and the second one forwards its input, the output frame carries both overlays.

The stage takes its frame size, box size, colour, speed and cross-hair position from static configuration inputs. Pixels enter and leave through valid/ready handshakes. Both sides carry start-of-frame and end-of-line markers. A start input and an auto-restart input decide whether the stage produces one frame or keeps producing frames.

Top module: `video_overlay_stage`

## Requirements
- R1: While rst_ni is low, m_valid_o and s_ready_o are both 0.
- R2: Raising start_i starts one frame. If auto_restart_i is 1 when the last pixel of a frame is issued, the next frame follows immediately. If it is 0, the stage goes quiet (s_ready_o=0, m_valid_o=0 once drained) until start_i has been low for a cycle and is raised again.
- R3: bg_sel_i selects the background: 0 forwards s_data_i and is the only mode in which s_ready_o can be 1. 1 gives Y = x mod 256. 2 gives Y = y mod 256. 3 gives Y = 0x10. Modes 1 to 3 use U = V = 0x80. Pixel layout is Y in [23:16], U in [15:8], V in [7:0].
- R4: m_sof_o is 1 only on the pixel at (0,0). m_eol_o is 1 on every pixel with x = width_i-1. In mode 0, an accepted beat with s_sof_i=1 is placed at (0,0), and an accepted beat with s_eol_i=1 ends its line.
- R5: fg_sel_i encodes 0 = no overlay, 1 = moving box, 2 = cross hairs; 3 behaves as 0.
- R6: With the box selected, every pixel with bx <= x < bx+box_size_i and by <= y < by+box_size_i takes the colour {box_y_i, box_u_i, box_v_i}. A size of 0 draws nothing.
- R7: The box starts at (0,0) moving right and down. After the last pixel of each frame is issued, each axis moves as follows, with lim = len-size when len > size and 0 otherwise. Moving forward: if pos+speed >= lim, then pos becomes lim and the direction turns back; otherwise pos becomes pos+speed. Moving back: if pos <= speed, then pos becomes 0 and the direction turns forward; otherwise pos becomes pos-speed.
- R8: With cross hairs selected, every pixel in column hair_x_i or row hair_y_i takes the box colour.
- R9: While m_valid_o=1 and m_ready_i=0, the output beat and its markers hold unchanged. No pixel is lost or repeated.
- R10: A beat accepted in mode 0 appears on the output in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Run request |
| auto_restart_i | input | 1 | Continue with the next frame after each frame |
| width_i | input | 12 | Active pixels per line |
| height_i | input | 12 | Active lines per frame |
| bg_sel_i | input | 2 | Background mode |
| fg_sel_i | input | 2 | Foreground mode |
| box_size_i | input | 9 | Box side in pixels |
| box_y_i | input | 8 | Overlay luma |
| box_u_i | input | 8 | Overlay chroma U |
| box_v_i | input | 8 | Overlay chroma V |
| speed_i | input | 5 | Box step per frame |
| hair_x_i | input | 12 | Cross-hair column |
| hair_y_i | input | 12 | Cross-hair row |
| s_valid_i | input | 1 | Upstream pixel valid |
| s_ready_o | output | 1 | Upstream pixel accepted |
| s_data_i | input | 24 | Upstream pixel |
| s_sof_i | input | 1 | Upstream start of frame |
| s_eol_i | input | 1 | Upstream end of line |
| m_valid_o | output | 1 | Output pixel valid |
| m_ready_i | input | 1 | Downstream ready |
| m_data_o | output | 24 | Output pixel |
| m_sof_o | output | 1 | Output start of frame |
| m_eol_o | output | 1 | Output end of line |

## Verification
The box position update and a downstream stall can fall in the same cycle. The update fires as the last pixel of a frame is issued, and that pixel may then sit in the output register while m_ready_i is low. The bench drives a ready pattern with period three against 48-pixel frames for several consecutive frames, so the stall walks across the frame ends. The held pixel must stay stable under the stall. The first pixel of the next frame must already show the box at its new position. An upstream start-of-frame marker arriving mid-line is also provoked, and the position restart is judged from the output markers and colours.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  typedef enum logic [1:0] {BG_PASS = 2'd0, BG_HRAMP = 2'd1, BG_VRAMP = 2'd2, BG_SOLID = 2'd3} bg_e;
  typedef enum logic [1:0] {FG_NONE = 2'd0, FG_BOX = 2'd1, FG_HAIR = 2'd2, FG_RSVD = 2'd3} fg_e;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_RUN = 2'd1, ST_HOLD = 2'd2} run_e;
endpackage

// File: rtl/ovl_axis.sv
module ovl_axis #(
  parameter int CNT_W   = 12,
  parameter int SIZE_W  = 9,
  parameter int SPEED_W = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               step_i,
  input  logic [CNT_W-1:0]   len_i,
  input  logic [SIZE_W-1:0]  size_i,
  input  logic [SPEED_W-1:0] speed_i,
  output logic [CNT_W-1:0]   pos_o
);
  logic [CNT_W-1:0] pos_q, lim, size_ext, speed_ext;
  logic [CNT_W:0]   sum;
  logic             back_q;

  always_comb begin
    size_ext  = CNT_W'(size_i);
    speed_ext = CNT_W'(speed_i);
    lim       = (len_i > size_ext) ? len_i - size_ext : '0;
    sum       = {1'b0, pos_q} + {1'b0, speed_ext};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= '0;
      back_q <= 1'b0;
    end else if (step_i) begin
      if (!back_q) begin
        if (sum >= {1'b0, lim}) begin
          pos_q  <= lim;
          back_q <= 1'b1;
        end else begin
          pos_q <= sum[CNT_W-1:0];
        end
      end else if (pos_q <= speed_ext) begin
        pos_q  <= '0;
        back_q <= 1'b0;
      end else begin
        pos_q <= pos_q - speed_ext;
      end
    end
  end

  assign pos_o = pos_q;
endmodule

// File: rtl/ovl_scan.sv
module ovl_scan #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  logic             restart_i,
  input  logic             line_end_i,
  input  logic [CNT_W-1:0] width_i,
  input  logic [CNT_W-1:0] height_i,
  output logic [CNT_W-1:0] x_o,
  output logic [CNT_W-1:0] y_o,
  output logic             eol_o,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  logic [CNT_W-1:0] x_q, y_q;

  // an upstream frame marker pins the current beat to the origin
  assign x_o    = restart_i ? '0 : x_q;
  assign y_o    = restart_i ? '0 : y_q;
  assign eol_o  = (x_o == width_i - ONE) || line_end_i;
  assign last_o = eol_o && (y_o == height_i - ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q <= '0;
      y_q <= '0;
    end else if (fire_i) begin
      if (eol_o) begin
        x_q <= '0;
        y_q <= last_o ? '0 : y_o + ONE;
      end else begin
        x_q <= x_o + ONE;
        y_q <= y_o;
      end
    end
  end
endmodule

// File: rtl/ovl_compose.sv
module ovl_compose import ovl_pkg::*; #(
  parameter int CNT_W  = 12,
  parameter int SIZE_W = 9,
  parameter int COMP_W = 8
) (
  input  logic [CNT_W-1:0]    x_i,
  input  logic [CNT_W-1:0]    y_i,
  input  logic [3*COMP_W-1:0] in_pix_i,
  input  logic [1:0]          bg_sel_i,
  input  logic [1:0]          fg_sel_i,
  input  logic [CNT_W-1:0]    box_x_i,
  input  logic [CNT_W-1:0]    box_y_i,
  input  logic [SIZE_W-1:0]   size_i,
  input  logic [3*COMP_W-1:0] colour_i,
  input  logic [CNT_W-1:0]    hair_x_i,
  input  logic [CNT_W-1:0]    hair_y_i,
  output logic [3*COMP_W-1:0] pix_o
);
  localparam logic [COMP_W-1:0] MID = COMP_W'(1) << (COMP_W - 1);
  localparam logic [COMP_W-1:0] BLK = MID >> 3;

  logic [3*COMP_W-1:0] base;
  logic [CNT_W:0]      x_end, y_end;
  logic                in_box, on_hair;

  always_comb begin
    unique case (bg_e'(bg_sel_i))
      BG_PASS:  base = in_pix_i;
      BG_HRAMP: base = {x_i[COMP_W-1:0], MID, MID};
      BG_VRAMP: base = {y_i[COMP_W-1:0], MID, MID};
      default:  base = {BLK, MID, MID};
    endcase
    x_end   = {1'b0, box_x_i} + (CNT_W+1)'(size_i);
    y_end   = {1'b0, box_y_i} + (CNT_W+1)'(size_i);
    in_box  = (x_i >= box_x_i) && ({1'b0, x_i} < x_end) &&
              (y_i >= box_y_i) && ({1'b0, y_i} < y_end);
    on_hair = (x_i == hair_x_i) || (y_i == hair_y_i);
    pix_o   = base;
    unique case (fg_e'(fg_sel_i))
      FG_BOX:  if (in_box)  pix_o = colour_i;
      FG_HAIR: if (on_hair) pix_o = colour_i;
      default: ;
    endcase
  end
endmodule

// File: rtl/video_overlay_stage.sv
module video_overlay_stage import ovl_pkg::*; #(
  parameter int CNT_W   = 12,
  parameter int SIZE_W  = 9,
  parameter int SPEED_W = 5,
  parameter int COMP_W  = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                auto_restart_i,
  input  logic [CNT_W-1:0]    width_i,
  input  logic [CNT_W-1:0]    height_i,
  input  logic [1:0]          bg_sel_i,
  input  logic [1:0]          fg_sel_i,
  input  logic [SIZE_W-1:0]   box_size_i,
  input  logic [COMP_W-1:0]   box_y_i,
  input  logic [COMP_W-1:0]   box_u_i,
  input  logic [COMP_W-1:0]   box_v_i,
  input  logic [SPEED_W-1:0]  speed_i,
  input  logic [CNT_W-1:0]    hair_x_i,
  input  logic [CNT_W-1:0]    hair_y_i,
  input  logic                s_valid_i,
  output logic                s_ready_o,
  input  logic [3*COMP_W-1:0] s_data_i,
  input  logic                s_sof_i,
  input  logic                s_eol_i,
  output logic                m_valid_o,
  input  logic                m_ready_i,
  output logic [3*COMP_W-1:0] m_data_o,
  output logic                m_sof_o,
  output logic                m_eol_o
);
  localparam int PIX_W  = 3 * COMP_W;
  localparam int N_AXIS = 2;

  run_e             st_q, st_d;
  logic             m_valid_q, m_sof_q, m_eol_q;
  logic [PIX_W-1:0] m_data_q, pix;
  logic             adv, pass, running, fire, frame_end;
  logic [CNT_W-1:0] px, py;
  logic             scan_eol, scan_last;
  logic [CNT_W-1:0] axis_len [N_AXIS];
  logic [CNT_W-1:0] axis_pos [N_AXIS];

  assign pass      = (bg_sel_i == BG_PASS);
  assign running   = (st_q == ST_RUN);
  assign adv       = !m_valid_q || m_ready_i;
  assign fire      = running && adv && (!pass || s_valid_i);
  assign s_ready_o = running && adv && pass;
  assign frame_end = fire && scan_last;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start_i) st_d = ST_RUN;
      ST_RUN:  if (frame_end && !auto_restart_i) st_d = ST_HOLD;
      ST_HOLD: if (!start_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  ovl_scan #(.CNT_W(CNT_W)) u_scan (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fire_i     (fire),
    .restart_i  (pass && s_sof_i),
    .line_end_i (pass && s_eol_i),
    .width_i    (width_i),
    .height_i   (height_i),
    .x_o        (px),
    .y_o        (py),
    .eol_o      (scan_eol),
    .last_o     (scan_last)
  );

  assign axis_len[0] = width_i;
  assign axis_len[1] = height_i;

  for (genvar g = 0; g < N_AXIS; g++) begin : g_axis
    ovl_axis #(.CNT_W(CNT_W), .SIZE_W(SIZE_W), .SPEED_W(SPEED_W)) u_axis (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .step_i  (frame_end),
      .len_i   (axis_len[g]),
      .size_i  (box_size_i),
      .speed_i (speed_i),
      .pos_o   (axis_pos[g])
    );
  end

  ovl_compose #(.CNT_W(CNT_W), .SIZE_W(SIZE_W), .COMP_W(COMP_W)) u_compose (
    .x_i      (px),
    .y_i      (py),
    .in_pix_i (s_data_i),
    .bg_sel_i (bg_sel_i),
    .fg_sel_i (fg_sel_i),
    .box_x_i  (axis_pos[0]),
    .box_y_i  (axis_pos[1]),
    .size_i   (box_size_i),
    .colour_i ({box_y_i, box_u_i, box_v_i}),
    .hair_x_i (hair_x_i),
    .hair_y_i (hair_y_i),
    .pix_o    (pix)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      m_valid_q <= 1'b0;
      m_data_q  <= '0;
      m_sof_q   <= 1'b0;
      m_eol_q   <= 1'b0;
    end else begin
      st_q <= st_d;
      if (adv) begin
        m_valid_q <= fire;
        if (fire) begin
          m_data_q <= pix;
          m_sof_q  <= (px == '0) && (py == '0);
          m_eol_q  <= scan_eol;
        end
      end
    end
  end

  assign m_valid_o = m_valid_q;
  assign m_data_o  = m_data_q;
  assign m_sof_o   = m_sof_q;
  assign m_eol_o   = m_eol_q;
endmodule

// File: rtl/ovl_stage_chk.sv
module ovl_stage_chk #(
  parameter int CNT_W  = 12,
  parameter int COMP_W = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [CNT_W-1:0]    width_i,
  input logic [1:0]          bg_sel_i,
  input logic [1:0]          fg_sel_i,
  input logic                s_valid_i,
  input logic                s_ready_o,
  input logic [3*COMP_W-1:0] s_data_i,
  input logic                m_valid_o,
  input logic                m_ready_i,
  input logic [3*COMP_W-1:0] m_data_o,
  input logic                m_sof_o,
  input logic                m_eol_o
);
  // R1
  always_comb begin
    if (rst_ni == 1'b0) reset_quiet_chk: assert (!m_valid_o && !s_ready_o);
  end

  // R9
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_valid_o && !m_ready_i |=> m_valid_o && $stable(m_data_o) && $stable(m_sof_o) && $stable(m_eol_o));

  // R3
  ready_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_ready_o |-> bg_sel_i == 2'd0);

  // R10
  pass_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_valid_i && s_ready_o && fg_sel_i == 2'd0 |=> m_valid_o && m_data_o == $past(s_data_i));

  // R4
  sof_eol_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_valid_o && m_sof_o && width_i > CNT_W'(1) && bg_sel_i != 2'd0 |-> !m_eol_o);
endmodule

bind video_overlay_stage ovl_stage_chk #(.CNT_W(CNT_W), .COMP_W(COMP_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .width_i   (width_i),
  .bg_sel_i  (bg_sel_i),
  .fg_sel_i  (fg_sel_i),
  .s_valid_i (s_valid_i),
  .s_ready_o (s_ready_o),
  .s_data_i  (s_data_i),
  .m_valid_o (m_valid_o),
  .m_ready_i (m_ready_i),
  .m_data_o  (m_data_o),
  .m_sof_o   (m_sof_o),
  .m_eol_o   (m_eol_o)
);

// File: tb/video_overlay_stage_tb.sv
module video_overlay_stage_tb;
  localparam int W = 8;
  localparam int H = 6;
  localparam int AREA = W * H;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, auto_restart_i = 1'b0;
  logic [11:0] width_i = 12'(W), height_i = 12'(H);
  logic [1:0]  bg_sel_i = 2'd0, fg_sel_i = 2'd0;
  logic [8:0]  box_size_i = 9'd3;
  logic [7:0]  box_y_i = 8'hA0, box_u_i = 8'h30, box_v_i = 8'hE0;
  logic [4:0]  speed_i = 5'd2;
  logic [11:0] hair_x_i = 12'd5, hair_y_i = 12'd2;
  logic        s_valid_i = 1'b0, s_sof_i = 1'b0, s_eol_i = 1'b0;
  logic [23:0] s_data_i = '0;
  logic        s_ready_o, m_valid_o, m_sof_o, m_eol_o;
  logic        m_ready_i = 1'b1;
  logic [23:0] m_data_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // box model per axis
  int mbx = 0, mby = 0;
  bit mbx_back = 0, mby_back = 0;

  logic [23:0] in_d [512];
  bit          in_s [512];
  bit          in_e [512];

  always #5 clk_i = ~clk_i;

  video_overlay_stage u_dut (.*);

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void step_axis(inout int pos, inout bit back, input int len);
    int lim;
    lim = (len > int'(box_size_i)) ? len - int'(box_size_i) : 0;
    if (!back) begin
      if (pos + int'(speed_i) >= lim) begin pos = lim; back = 1; end
      else pos = pos + int'(speed_i);
    end else begin
      if (pos <= int'(speed_i)) begin pos = 0; back = 0; end
      else pos = pos - int'(speed_i);
    end
  endfunction

  function automatic logic [23:0] exp_pix(input int x, input int y, input logic [23:0] din);
    logic [23:0] p;
    int sz;
    sz = int'(box_size_i);
    case (bg_sel_i)
      2'd0: p = din;
      2'd1: p = {8'(x), 8'h80, 8'h80};
      2'd2: p = {8'(y), 8'h80, 8'h80};
      default: p = {8'h10, 8'h80, 8'h80};
    endcase
    if (fg_sel_i == 2'd1 && x >= mbx && x < mbx + sz && y >= mby && y < mby + sz)
      p = {box_y_i, box_u_i, box_v_i};
    if (fg_sel_i == 2'd2 && (x == int'(hair_x_i) || y == int'(hair_y_i)))
      p = {box_y_i, box_u_i, box_v_i};
    return p;
  endfunction

  // drive and compare n_out output beats; sof_at injects an upstream frame marker
  task automatic stream(input int n_out, input bit pass, input int sof_at, input bit stall,
                        input bit auto_stop, input string tag);
    int ki = 0, ko = 0, cyc = 0, px = 0, py = 0, uc = 0;
    bit acc, obs, prev_acc = 0, hold_pend = 0;
    logic [23:0] held = '0;
    for (int k = 0; k < 512; k++) begin
      if (k == sof_at) uc = 0;
      in_d[k] = {8'(k * 7), 8'(k * 3 + 1), 8'(255 - k)};
      in_s[k] = (uc == 0);
      in_e[k] = ((uc % W) == W - 1);
      uc = (uc + 1) % AREA;
    end
    while (ko < n_out && cyc < 5000) begin
      @(negedge clk_i);
      cyc++;
      m_ready_i = stall ? (cyc % 3 != 2) : 1'b1;
      if (pass) begin
        s_valid_i = (ki < n_out) && (!stall || cyc % 5 != 4);
        s_data_i  = in_d[ki];
        s_sof_i   = in_s[ki];
        s_eol_i   = in_e[ki];
      end else begin
        s_valid_i = 1'b0;
      end
      #1;
      if (hold_pend) // R9: stalled beat must still be there
        check(m_valid_o && m_data_o == held, "R9 stall hold", {7'd0, m_valid_o, m_data_o}, {8'd1, held});
      hold_pend = m_valid_o && !m_ready_i;
      held = m_data_o;
      if (prev_acc && pass && !stall) // R10 one-cycle latency
        check(m_valid_o, "R10 latency", 32'(m_valid_o), 32'd1);
      acc = s_valid_i && s_ready_o;
      obs = m_valid_o && m_ready_i;
      if (obs) begin
        int ox, oy;
        bit eol_e, sof_e, last;
        logic [23:0] e;
        ox = px; oy = py;
        if (pass && in_s[ko]) begin ox = 0; oy = 0; end
        eol_e = (ox == W - 1) || (pass && in_e[ko]);
        last  = eol_e && (oy == H - 1);
        sof_e = (ox == 0) && (oy == 0);
        e = exp_pix(ox, oy, pass ? in_d[ko] : 24'd0);
        check(m_data_o == e && m_sof_o == sof_e && m_eol_o == eol_e, tag,
              {6'd0, m_sof_o, m_eol_o, m_data_o}, {6'd0, sof_e, eol_e, e});
        if (eol_e) begin px = 0; py = last ? 0 : oy + 1; end
        else begin px = ox + 1; py = oy; end
        if (last) begin
          step_axis(mbx, mbx_back, W);
          step_axis(mby, mby_back, H);
        end
        ko++;
        if (auto_stop && ko == n_out - AREA + 1) auto_restart_i = 1'b0;
      end
      if (acc) ki++;
      prev_acc = acc;
    end
    check(ko == n_out, {tag, " beat count"}, 32'(ko), 32'(n_out));
    s_valid_i = 1'b0;
    m_ready_i = 1'b1;
  endtask

  task automatic quiet(input int n, input string tag);
    bit ok = 1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); #1;
      if (m_valid_o || s_ready_o) ok = 0;
    end
    check(ok, tag, 32'(ok), 32'd1);
  endtask

  task automatic stop_run;
    start_i = 1'b0;
    auto_restart_i = 1'b0;
    repeat (3) @(negedge clk_i);
  endtask

  task automatic t_reset;
    #1;
    check(!m_valid_o && !s_ready_o, "R1 reset", {30'd0, m_valid_o, s_ready_o}, 32'd0);
  endtask

  task automatic t_ramp_oneshot;
    bg_sel_i = 2'd1; fg_sel_i = 2'd0;
    start_i = 1'b1;
    stream(AREA, 0, -1, 0, 0, "R3 horizontal ramp");
    quiet(20, "R2 one-shot stays quiet while start held");
    stop_run();
  endtask

  task automatic t_box_auto;
    bg_sel_i = 2'd3; fg_sel_i = 2'd1;
    start_i = 1'b1; auto_restart_i = 1'b1;
    stream(5 * AREA, 0, -1, 1, 1, "R7 R6 bouncing box");
    quiet(20, "R2 stop after auto-restart cleared");
    stop_run();
  endtask

  task automatic t_pass_hair;
    bg_sel_i = 2'd0; fg_sel_i = 2'd2;
    start_i = 1'b1; auto_restart_i = 1'b1;
    stream(2 * AREA, 1, -1, 1, 1, "R8 cross hairs over upstream");
    stop_run();
    bg_sel_i = 2'd0; fg_sel_i = 2'd0;
    start_i = 1'b1;
    stream(AREA, 1, -1, 0, 0, "R10 plain forward");
    stop_run();
  endtask

  task automatic t_sof_resync;
    bg_sel_i = 2'd0; fg_sel_i = 2'd1;
    start_i = 1'b1;
    stream(3 + AREA, 1, 3, 0, 0, "R4 upstream frame marker");
    stop_run();
  endtask

  task automatic t_rsvd_fg;
    bg_sel_i = 2'd2; fg_sel_i = 2'd3;
    start_i = 1'b1;
    stream(AREA, 0, -1, 0, 0, "R5 reserved foreground");
    stop_run();
  endtask

  task automatic t_box_sizes;
    bg_sel_i = 2'd3; fg_sel_i = 2'd1;
    box_size_i = 9'd0;
    start_i = 1'b1;
    stream(AREA, 0, -1, 0, 0, "R6 zero size");
    stop_run();
    box_size_i = 9'd200;
    start_i = 1'b1; auto_restart_i = 1'b1;
    stream(2 * AREA, 0, -1, 0, 1, "R6 R7 oversize box");
    stop_run();
    box_size_i = 9'd3;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_ramp_oneshot();
    t_box_auto();
    t_pass_hair();
    t_sof_resync();
    t_rsvd_fg();
    t_box_sizes();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule